// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two IEEE-754 binary operands and answers one of three questions: are they equal, is the first strictly below the second, or is the first at or below the second. It is purely combinational. A single parameter picks the storage format (half, single or double width). The exponent and fraction widths of each operand are derived from that parameter.

Each operand passes through its own classifier. The classifier splits the operand into sign, biased exponent and fraction, and marks it as a zero, a quiet NaN or a signaling NaN. An ordering stage ranks the two operands by sign and magnitude, with +0 and -0 treated as the same value. The output stage chooses the answer for the requested operation, forces it low when a NaN is present, and raises the invalid-operation bit of a five-bit exception flag vector as the mode requires.

The operation select behaves like the decode of a small state set: `CMP_EQ` (00), `CMP_LT` (01), `CMP_LE` (10) and `CMP_RSVD` (11). Each input pattern goes straight to its answer with no stored state.

Top module: `fp_compare_unit`

## Requirements
- R1: Parameter `FW` accepts 16, 32 or 64. The exponent and fraction widths are 5/10, 8/23 and 11/52 respectively, with the sign in the top bit. A NaN has all exponent bits set and a non-zero fraction. It is quiet when the fraction MSB is 1 and signaling when that bit is 0.
- R2: With `op_sel`=00 (equal), `result` is 1 when the two bit patterns are identical or when both operands are zeros of any sign.
- R3: With `op_sel`=01 (less-than), operands are ordered by sign and magnitude. For two positives, the exponent decides and then the fraction decides. For two negatives the sense is reversed. A negative operand is below any positive one, except that -0 is not below +0.
- R4: With `op_sel`=10 (less-or-equal), `result` is 1 when less-than holds or when the values are equal. A positive first operand against a negative second operand gives 1 only when both are zeros.
- R5: -0 against +0, in either order, gives 0 for less-than and 1 for less-or-equal.
- R6: If either operand is any NaN, `result` is 0 for every operation and mode.
- R7: For equality, `flags` bit 4 (invalid) is set only when an operand is a signaling NaN, whatever the value of `sig_mode`.
- R8: For less-than and less-or-equal with `sig_mode`=0 (quiet), bit 4 is set only when an operand is a signaling NaN.
- R9: For less-than and less-or-equal with `sig_mode`=1 (signaling), bit 4 is set when either operand is any NaN.
- R10: `flags` bits 3..0 (divide-by-zero at bit 3, overflow at bit 2, underflow at bit 1, inexact at bit 0) are always 0.
- R11: `op_sel`=11 is reserved and gives `result`=0 and `flags`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | FW | First operand |
| opb | input | FW | Second operand |
| op_sel | input | 2 | 00 equal, 01 less-than, 10 less-or-equal, 11 reserved |
| sig_mode | input | 1 | 1 = signaling ordered compare, 0 = quiet |
| result | output | 1 | Answer of the selected compare |
| flags | output | 5 | Exception flags, bit 4 invalid |

## Verification
Every output is a combinational function of the inputs, so both `result` and `flags` are due in the same cycle as the stimulus. The bench applies new operands just after a rising edge and samples at the following falling edge. By then all paths have settled, and no register lies between input and output. Directed corner cases and biased random operands are both checked against a bench model that ranks values as signed integer keys.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        CMP_EQ   = 2'b00,
        CMP_LT   = 2'b01,
        CMP_LE   = 2'b10,
        CMP_RSVD = 2'b11
    } cmp_op_e;

    typedef enum logic [1:0] {
        SGN_PP = 2'b00,
        SGN_PN = 2'b01,
        SGN_NP = 2'b10,
        SGN_NN = 2'b11
    } sgn_case_e;

    localparam logic [4:0] FLG_INVALID = 5'b10000;
    localparam logic [4:0] FLG_NONE    = 5'b00000;

    function automatic int exp_bits(input int fw);
        case (fw)
            16:      return 5;
            64:      return 11;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int FW = 32,
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  logic [FW-1:0] val_i,
    output logic          sgn_o,
    output logic [EW-1:0] exp_o,
    output logic [MW-1:0] man_o,
    output logic          zero_o,
    output logic          nan_o,
    output logic          snan_o
);
    logic exp_ones;

    always_comb begin
        sgn_o    = val_i[FW-1];
        exp_o    = val_i[FW-2 -: EW];
        man_o    = val_i[MW-1:0];
        exp_ones = &exp_o;
        zero_o   = (exp_o == '0) && (man_o == '0);
        nan_o    = exp_ones && (man_o != '0);
        snan_o   = nan_o && !man_o[MW-1];
    end

    always_comb begin
        // R1
        nan_not_zero_chk: assert (!(nan_o && zero_o));
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  logic          sa_i,
    input  logic          sb_i,
    input  logic [EW-1:0] ea_i,
    input  logic [EW-1:0] eb_i,
    input  logic [MW-1:0] ma_i,
    input  logic [MW-1:0] mb_i,
    input  logic          za_i,
    input  logic          zb_i,
    output logic          lt_o,
    output logic          le_o,
    output logic          eq_o
);
    localparam int MAGW = EW + MW;

    logic [MAGW-1:0] mag_a, mag_b;
    logic            mag_lt, mag_gt, mag_eq, both_zero;
    sgn_case_e       sc;

    always_comb begin
        mag_a     = {ea_i, ma_i};
        mag_b     = {eb_i, mb_i};
        mag_lt    = mag_a < mag_b;
        mag_gt    = mag_a > mag_b;
        mag_eq    = mag_a == mag_b;
        both_zero = za_i && zb_i;
        sc        = sgn_case_e'({sa_i, sb_i});
    end

    always_comb begin
        unique case (sc)
            SGN_PP: begin
                lt_o = mag_lt;
                le_o = mag_lt || mag_eq;
            end
            SGN_NN: begin
                lt_o = mag_gt;
                le_o = mag_gt || mag_eq;
            end
            SGN_PN: begin
                lt_o = 1'b0;
                le_o = both_zero;
            end
            SGN_NP: begin
                lt_o = !both_zero;
                le_o = 1'b1;
            end
            default: begin
                lt_o = 1'b0;
                le_o = 1'b0;
            end
        endcase
        eq_o = ((sa_i == sb_i) && mag_eq) || both_zero;
    end

    always_comb begin
        // R4
        lt_implies_le_chk: assert (!(lt_o && !le_o));
        // R3
        lt_excludes_eq_chk: assert (!(lt_o && eq_o));
    end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
    import fcmp_pkg::*;
#(
    parameter int FW = 32
) (
    input  logic [FW-1:0] opa,
    input  logic [FW-1:0] opb,
    input  logic [1:0]    op_sel,
    input  logic          sig_mode,
    output logic          result,
    output logic [4:0]    flags
);
    localparam int EW = exp_bits(FW);
    localparam int MW = FW - 1 - EW;

    logic [FW-1:0] opv  [2];
    logic          sgn  [2];
    logic [EW-1:0] expv [2];
    logic [MW-1:0] manv [2];
    logic          zro  [2];
    logic          nan  [2];
    logic          snan [2];

    assign opv[0] = opa;
    assign opv[1] = opb;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fcmp_classify #(.FW(FW), .EW(EW), .MW(MW)) cls_i (
            .val_i  (opv[gi]),
            .sgn_o  (sgn[gi]),
            .exp_o  (expv[gi]),
            .man_o  (manv[gi]),
            .zero_o (zro[gi]),
            .nan_o  (nan[gi]),
            .snan_o (snan[gi])
        );
    end

    logic ord_lt, ord_le, ord_eq;

    fcmp_order #(.EW(EW), .MW(MW)) ord_i (
        .sa_i (sgn[0]),  .sb_i (sgn[1]),
        .ea_i (expv[0]), .eb_i (expv[1]),
        .ma_i (manv[0]), .mb_i (manv[1]),
        .za_i (zro[0]),  .zb_i (zro[1]),
        .lt_o (ord_lt),  .le_o (ord_le),
        .eq_o (ord_eq)
    );

    logic    any_nan, any_snan, raise_inv;
    cmp_op_e op;

    always_comb begin
        op       = cmp_op_e'(op_sel);
        any_nan  = nan[0] || nan[1];
        any_snan = snan[0] || snan[1];
        unique case (op)
            CMP_EQ: begin
                result    = ord_eq && !any_nan;
                raise_inv = any_snan;
            end
            CMP_LT: begin
                result    = ord_lt && !any_nan;
                raise_inv = sig_mode ? any_nan : any_snan;
            end
            CMP_LE: begin
                result    = ord_le && !any_nan;
                raise_inv = sig_mode ? any_nan : any_snan;
            end
            default: begin
                result    = 1'b0;
                raise_inv = 1'b0;
            end
        endcase
        flags = raise_inv ? FLG_INVALID : FLG_NONE;
    end

    always_comb begin
        // R6
        nan_gives_false_chk: assert (!(any_nan && result));
        // R2
        zeros_equal_chk: assert (!(op == CMP_EQ && zro[0] && zro[1] && !result));
        // R7
        snan_raises_inv_chk: assert (!(any_snan && op != CMP_RSVD && !flags[4]));
        // R11
        rsvd_quiet_chk: assert (!(op == CMP_RSVD && (result || flags != 5'b0)));
    end
endmodule

// File: tb/fp_compare_unit_tb_top.sv
module fp_compare_unit_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [63:0] a_r = '0, b_r = '0;
    logic [1:0]  op_r = 2'b00;
    logic        sm_r = 1'b0;
    logic        res16, res32, res64;
    logic [4:0]  fl16, fl32, fl64;

    int checks = 0, errors = 0;
    bit done = 0;

    fp_compare_unit #(.FW(16)) dut16_i (.opa(a_r[15:0]), .opb(b_r[15:0]), .op_sel(op_r),
        .sig_mode(sm_r), .result(res16), .flags(fl16));
    fp_compare_unit #(.FW(32)) dut_i (.opa(a_r[31:0]), .opb(b_r[31:0]), .op_sel(op_r),
        .sig_mode(sm_r), .result(res32), .flags(fl32));
    fp_compare_unit #(.FW(64)) dut64_i (.opa(a_r), .opb(b_r), .op_sel(op_r),
        .sig_mode(sm_r), .result(res64), .flags(fl64));

    function automatic void model(input int w, input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] op, input logic sm,
                                  output logic res, output logic [4:0] fl);
        int ew, mw;
        logic [63:0] emask, mmask, vmask, ma, mb, fa, fb, xa, xb;
        logic sa, sb, na, nb, qa, qb;
        logic signed [65:0] ka, kb;
        ew = (w == 16) ? 5 : (w == 32) ? 8 : 11;
        mw = w - 1 - ew;
        emask = (64'd1 << ew) - 64'd1;
        mmask = (64'd1 << mw) - 64'd1;
        vmask = (64'd1 << (w - 1)) - 64'd1;
        sa = a[w-1]; sb = b[w-1];
        ma = a & vmask; mb = b & vmask;
        xa = (a >> mw) & emask; xb = (b >> mw) & emask;
        fa = a & mmask; fb = b & mmask;
        na = (xa == emask) && (fa != 0);
        nb = (xb == emask) && (fb != 0);
        qa = fa[mw-1]; qb = fb[mw-1];
        ka = sa ? -$signed({2'b00, ma}) : $signed({2'b00, ma});
        kb = sb ? -$signed({2'b00, mb}) : $signed({2'b00, mb});
        res = 1'b0;
        fl = 5'b0;
        if (op == 2'b11) return;
        if (na || nb) begin
            if (op != 2'b00 && sm) fl = 5'b10000;
            else if ((na && !qa) || (nb && !qb)) fl = 5'b10000;
            return;
        end
        case (op)
            2'b00:   res = (ka == kb);
            2'b01:   res = (ka < kb);
            default: res = (ka <= kb);
        endcase
    endfunction

    task automatic run(input int w, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] op, input logic sm, input string tag);
        logic er, ar;
        logic [4:0] ef, af;
        @(posedge clk);
        #1;
        a_r = a; b_r = b; op_r = op; sm_r = sm;
        @(negedge clk);
        model(w, a, b, op, sm, er, ef);
        ar = (w == 16) ? res16 : (w == 32) ? res32 : res64;
        af = (w == 16) ? fl16 : (w == 32) ? fl32 : fl64;
        checks++;
        if (ar !== er || af !== ef) begin
            errors++;
            $display("FAIL %s w=%0d a=%h b=%h op=%0d sm=%0d: got res=%0d flags=%b expected res=%0d flags=%b",
                     tag, w, a, b, op, sm, ar, af, er, ef);
        end
        checks++;
        if (af[3:0] !== 4'b0) begin
            errors++;
            $display("FAIL R10 low flag bits got %b expected 0000", af[3:0]);
        end
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic sm);
        case (op)
            2'b00:   return "R2/R7";
            2'b01:   return sm ? "R3/R9" : "R3/R8";
            2'b10:   return sm ? "R4/R9" : "R4/R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [63:0] pick(input int w, input logic [63:0] other);
        int ew, mw;
        logic [63:0] r, emask, sg;
        ew = (w == 16) ? 5 : (w == 32) ? 8 : 11;
        mw = w - 1 - ew;
        emask = ((64'd1 << ew) - 64'd1) << mw;
        sg = ($urandom % 2) ? (64'd1 << (w - 1)) : 64'd0;
        r = {$urandom, $urandom};
        case ($urandom % 9)
            0: r = sg;
            1: r = sg | emask;
            2: r = sg | emask | (64'd1 << (mw - 1)) | ($urandom % 7);
            3: r = sg | emask | (64'd1 + ($urandom % 5));
            4: r = other;
            5: r = other ^ (64'd1 << (w - 1));
            6: r = other + ($urandom % 3) - 1;
            default: r = r;
        endcase
        if (w < 64) r = r & ((64'd1 << w) - 64'd1);
        return r;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        process::self().srandom(32'd20240404);
        // initial state: all-zero inputs, equal op
        @(negedge clk);
        checks++;
        if (res32 !== 1'b1 || fl32 !== 5'b0) begin
            errors++;
            $display("FAIL R2 initial got res=%0d flags=%b expected res=1 flags=00000", res32, fl32);
        end
        // R5 signed zeros
        run(32, 64'h0000_0000, 64'h8000_0000, 2'b00, 1'b0, "R5");
        run(32, 64'h8000_0000, 64'h0000_0000, 2'b01, 1'b0, "R5");
        run(32, 64'h0000_0000, 64'h8000_0000, 2'b01, 1'b1, "R5");
        run(32, 64'h8000_0000, 64'h0000_0000, 2'b10, 1'b0, "R5");
        run(32, 64'h0000_0000, 64'h8000_0000, 2'b10, 1'b0, "R5");
        // R3 / R4 ordering
        run(32, 64'h3f80_0000, 64'h4000_0000, 2'b01, 1'b0, "R3");
        run(32, 64'hc000_0000, 64'hbf80_0000, 2'b01, 1'b0, "R3");
        run(32, 64'hbf80_0000, 64'hc000_0000, 2'b01, 1'b0, "R3");
        run(32, 64'h3f80_0000, 64'hbf80_0000, 2'b10, 1'b0, "R4");
        run(32, 64'hbf80_0000, 64'hbf80_0000, 2'b10, 1'b0, "R4");
        run(32, 64'h3f80_0001, 64'h3f80_0000, 2'b10, 1'b0, "R4");
        // R6 / R7 / R8 / R9 NaNs
        run(32, 64'h7fc0_0000, 64'h7fc0_0000, 2'b00, 1'b1, "R6/R7");
        run(32, 64'h7f80_0001, 64'h3f80_0000, 2'b00, 1'b0, "R7");
        run(32, 64'h7fc0_0000, 64'h3f80_0000, 2'b01, 1'b0, "R8");
        run(32, 64'h7f80_0001, 64'h3f80_0000, 2'b10, 1'b0, "R8");
        run(32, 64'h3f80_0000, 64'h7fc0_0000, 2'b01, 1'b1, "R9");
        run(32, 64'hffc0_0000, 64'hff80_0000, 2'b10, 1'b1, "R9");
        run(32, 64'h7f80_0000, 64'h7f80_0000, 2'b10, 1'b1, "R9");
        // R11 reserved
        run(32, 64'h7f80_0001, 64'h0000_0000, 2'b11, 1'b1, "R11");
        run(32, 64'h0000_0000, 64'h0000_0000, 2'b11, 1'b0, "R11");
        // R1 other widths
        run(16, 64'h3c00, 64'h4000, 2'b01, 1'b0, "R1");
        run(16, 64'h7c01, 64'h0000, 2'b00, 1'b0, "R1");
        run(16, 64'h7e00, 64'h0000, 2'b00, 1'b0, "R1");
        run(64, 64'h3ff0_0000_0000_0000, 64'h4000_0000_0000_0000, 2'b01, 1'b0, "R1");
        run(64, 64'h7ff0_0000_0000_0001, 64'h0, 2'b10, 1'b0, "R1");
        run(64, 64'h7ff8_0000_0000_0000, 64'h0, 2'b10, 1'b0, "R1");
        // random
        for (int w = 0; w < 3; w++) begin
            int wd;
            wd = (w == 0) ? 16 : (w == 1) ? 32 : 64;
            for (int k = 0; k < 800; k++) begin
                logic [63:0] ra, rb;
                logic [1:0] ro;
                logic rs;
                ra = pick(wd, 64'd0);
                rb = pick(wd, ra);
                ro = 2'($urandom % 4);
                rs = 1'($urandom % 2);
                run(wd, ra, rb, ro, rs, tag_of(ro, rs));
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule